// File: doc/BRIEF.md
# Reconfiguration Bitstream Streaming Sequencer

This block sits between a host and a partial-reconfiguration controller and runs one reconfiguration operation per host request. The host gives a word count and a timeout, then pulses a go strobe. The sequencer raises a start request toward the controller for exactly one cycle. It then passes bitstream words from an upstream FIFO-style source to the controller over a valid/ready handshake with zero ready latency, and counts every accepted word.

After the last real word, or when the controller reports an error part way through, the sequencer stops taking words from the source. Depending on a parameter, it either drops valid or offers a fixed filler word. It detects the end of the operation from the controller's freeze flag falling, or from the 3-bit status showing a terminal code. After the end it keeps watching the status for a short settle window, so that a late CRC error still counts. A timeout bounds the wait for the end. The result goes back to the host as a one-cycle done pulse, with a registered pass bit and a 3-bit code.

Top module: `pr_stream_seq`

## Requirements
- R1: A go pulse while idle starts an operation and busy_o rises with the start request. A go pulse while busy_o is high has no effect, and its word count is not used.
- R2: pr_start_o is high for exactly one cycle, the cycle after go is accepted, and pr_valid_o is low in that cycle. The start request is therefore released before any word is offered.
- R3: While streaming, pr_valid_o follows src_valid_i and pr_data_o follows src_data_i. src_ready_o follows pr_ready_i in the same cycle, with zero latency. Exactly word_cnt_i words are transferred, in order. A count of zero transfers no word.
- R4: Once the stream is complete, src_ready_o stays low. With FILL_EN=1, pr_valid_o stays high with pr_data_o equal to FILL_WORD until the end is detected. With FILL_EN=0, pr_valid_o is low.
- R5: When the controller drops pr_ready_i after the last word, the sequencer does not wait for more data. It goes on to detect the end and reports.
- R6: The end of an operation is a falling edge of pr_freeze_i, or a status of 101 (passed) or of an error code. A status of 101 with freeze still high ends the operation with a pass.
- R7: The status codes 001 (reconfiguration error), 010 (CRC error) and 011 (incompatible bitstream) seen during streaming stop the transfer at once. The operation then fails with that code.
- R8: After the end is detected, status is watched for SETTLE more cycles. A 010 code that appears in that window turns the result into a fail with code 010. The first error code seen is kept.
- R9: If no end is seen within timeout_i+1 cycles after the waiting phase begins, the operation fails with code 100.
- R10: done_o is a one-cycle pulse as the block returns to idle. On success, pass_o=1 and code_o=101. On any failure, pass_o=0 and code_o holds the error code.
- R11: After reset, busy_o, done_o, pr_start_o, pr_valid_o and src_ready_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Host request to begin an operation |
| word_cnt_i | input | CNT_W | Number of bitstream words, sampled with go_i |
| timeout_i | input | TO_W | Cycles to wait for the end after the stream completes |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Registered result, 1 on success |
| code_o | output | 3 | Registered result code |
| src_data_i | input | DW | Word from the upstream source |
| src_valid_i | input | 1 | Source word available |
| src_ready_o | output | 1 | Source word taken this cycle |
| pr_start_o | output | 1 | Start request to the controller |
| pr_data_o | output | DW | Word to the controller |
| pr_valid_o | output | 1 | Word offered to the controller |
| pr_ready_i | input | 1 | Controller accepts the word |
| pr_status_i | input | 3 | Controller status code |
| pr_freeze_i | input | 1 | Controller freeze flag |

## Verification
The bench aims at the moment the controller lowers ready after the final word. A design that treats this as a stall hangs, and one that keeps counting pulls extra words from the source. It injects errors at word zero and in the middle of the stream, where a design that ignores status goes on streaming and reports a pass. It raises a CRC error two cycles after freeze falls, which a design that samples status only once would miss. It also covers the cases of freeze never falling, of a zero-length stream, and of a second go strobe during a run. These show a missing timeout, a stuck start state, or a word count overwritten in mid-operation.

// File: rtl/pr_seq_pkg.sv
package pr_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_STREAM, S_DRAIN, S_WAIT, S_REPORT
  } seq_state_e;

  localparam logic [2:0] ST_IDLE     = 3'b000;
  localparam logic [2:0] ST_PR_ERR   = 3'b001;
  localparam logic [2:0] ST_CRC_ERR  = 3'b010;
  localparam logic [2:0] ST_INCOMPAT = 3'b011;
  localparam logic [2:0] ST_BUSY     = 3'b100;
  localparam logic [2:0] ST_OK       = 3'b101;

  function automatic logic is_err(logic [2:0] s);
    return (s == ST_PR_ERR) || (s == ST_CRC_ERR) || (s == ST_INCOMPAT);
  endfunction
endpackage

// File: rtl/pr_seq_cnt.sv
module pr_seq_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == W'(1));

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |=> (cnt_q != {W{1'b1}})); // R3
endmodule

// File: rtl/pr_seq_path.sv
module pr_seq_path #(
  parameter int            DW        = 32,
  parameter bit            FILL_EN   = 1'b1,
  parameter logic [DW-1:0] FILL_WORD = '0
) (
  input  logic          stream_i,
  input  logic          pad_i,
  input  logic [DW-1:0] src_data_i,
  input  logic          src_valid_i,
  input  logic          pr_ready_i,
  output logic          src_ready_o,
  output logic [DW-1:0] pr_data_o,
  output logic          pr_valid_o
);
  logic pad_vld;

  generate
    if (FILL_EN) begin : g_fill
      assign pad_vld = pad_i;
    end else begin : g_nofill
      logic unused_pad;
      assign unused_pad = pad_i;
      assign pad_vld    = 1'b0;
    end
  endgenerate

  // zero-latency pass-through while streaming, filler or quiet afterwards
  assign pr_valid_o  = stream_i ? src_valid_i : pad_vld;
  assign pr_data_o   = stream_i ? src_data_i : (pad_vld ? FILL_WORD : '0);
  assign src_ready_o = stream_i & pr_ready_i;
endmodule

// File: rtl/pr_seq_mon.sv
module pr_seq_mon
  import pr_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       mon_i,
  input  logic [2:0] status_i,
  input  logic       freeze_i,
  output logic       err_o,
  output logic [2:0] err_code_o,
  output logic       end_o
);
  logic       freeze_q, end_q, now_err, now_end;
  logic [2:0] err_q;

  assign now_err = mon_i & is_err(status_i);
  assign now_end = mon_i & ((freeze_q & ~freeze_i) | (status_i == ST_OK) | is_err(status_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freeze_q <= 1'b0;
      end_q    <= 1'b0;
      err_q    <= ST_IDLE;
    end else begin
      freeze_q <= freeze_i;
      if (clr_i) begin
        end_q <= 1'b0;
        err_q <= ST_IDLE;
      end else begin
        if (now_end) end_q <= 1'b1;
        if (err_q == ST_IDLE && now_err) err_q <= status_i; // first error wins
      end
    end
  end

  assign err_code_o = (err_q != ST_IDLE) ? err_q : (now_err ? status_i : ST_IDLE);
  assign err_o      = (err_code_o != ST_IDLE);
  assign end_o      = end_q | now_end;

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q != ST_IDLE && !clr_i) |=> (err_q == $past(err_q))); // R8
  AST_END_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_q && !clr_i) |=> end_q); // R6
endmodule

// File: rtl/pr_stream_seq.sv
module pr_stream_seq
  import pr_seq_pkg::*;
#(
  parameter int            DW        = 32,
  parameter int            CNT_W     = 16,
  parameter int            TO_W      = 16,
  parameter int            SETTLE    = 4,
  parameter bit            FILL_EN   = 1'b1,
  parameter logic [DW-1:0] FILL_WORD = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [CNT_W-1:0] word_cnt_i,
  input  logic [TO_W-1:0]  timeout_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic [2:0]       code_o,
  input  logic [DW-1:0]    src_data_i,
  input  logic             src_valid_i,
  output logic             src_ready_o,
  output logic             pr_start_o,
  output logic [DW-1:0]    pr_data_o,
  output logic             pr_valid_o,
  input  logic             pr_ready_i,
  input  logic [2:0]       pr_status_i,
  input  logic             pr_freeze_i
);
  localparam int SET_W = (SETTLE < 2) ? 1 : $clog2(SETTLE);

  seq_state_e state_q, state_d;
  logic       in_stream, in_pad, mon_act, xfer;
  logic       end_seen, err_seen;
  logic [2:0] err_code;
  logic       w_zero, w_last, t_zero, t_last, s_zero, s_last;
  logic       w_load, t_load, t_dec, s_load, s_dec;
  logic       to_q, done_q, pass_q;
  logic [2:0] code_q;
  logic       unused_last;

  assign in_stream = (state_q == S_STREAM);
  assign in_pad    = (state_q == S_DRAIN) || (state_q == S_WAIT);
  assign mon_act   = in_stream || in_pad || (state_q == S_REPORT);

  pr_seq_path #(.DW(DW), .FILL_EN(FILL_EN), .FILL_WORD(FILL_WORD)) u_path (
    .stream_i   (in_stream),
    .pad_i      (in_pad),
    .src_data_i (src_data_i),
    .src_valid_i(src_valid_i),
    .pr_ready_i (pr_ready_i),
    .src_ready_o(src_ready_o),
    .pr_data_o  (pr_data_o),
    .pr_valid_o (pr_valid_o)
  );

  assign xfer = in_stream & pr_valid_o & pr_ready_i;

  pr_seq_mon u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (state_q == S_START),
    .mon_i     (mon_act),
    .status_i  (pr_status_i),
    .freeze_i  (pr_freeze_i),
    .err_o     (err_seen),
    .err_code_o(err_code),
    .end_o     (end_seen)
  );

  assign w_load = (state_q == S_IDLE) && go_i;
  assign t_load = (state_q == S_DRAIN);
  assign t_dec  = (state_q == S_WAIT) && !end_seen && !t_zero;
  assign s_load = (state_q == S_WAIT) && (end_seen || t_zero);
  assign s_dec  = (state_q == S_REPORT) && !s_zero;

  pr_seq_cnt #(.W(CNT_W)) u_words (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(w_load), .val_i(word_cnt_i),
    .dec_i(xfer), .zero_o(w_zero), .last_o(w_last)
  );

  pr_seq_cnt #(.W(TO_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(t_load), .val_i(timeout_i),
    .dec_i(t_dec), .zero_o(t_zero), .last_o(t_last)
  );

  pr_seq_cnt #(.W(SET_W)) u_settle (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(s_load), .val_i(SET_W'(SETTLE - 1)),
    .dec_i(s_dec), .zero_o(s_zero), .last_o(s_last)
  );

  assign unused_last = t_last ^ s_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (go_i) state_d = S_START;
      S_START:  state_d = w_zero ? S_DRAIN : S_STREAM;
      S_STREAM: if (err_seen || (xfer && w_last)) state_d = S_DRAIN;
      S_DRAIN:  state_d = S_WAIT;
      S_WAIT:   if (end_seen || t_zero) state_d = S_REPORT;
      S_REPORT: if (s_zero) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      to_q    <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      code_q  <= ST_IDLE;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if (state_q == S_START) to_q <= 1'b0;
      if (state_q == S_WAIT && !end_seen && t_zero) to_q <= 1'b1;
      if (state_q == S_REPORT && s_zero) begin
        done_q <= 1'b1;
        if (to_q) begin
          pass_q <= 1'b0;
          code_q <= ST_BUSY;
        end else if (err_seen) begin
          pass_q <= 1'b0;
          code_q <= err_code;
        end else begin
          pass_q <= 1'b1;
          code_q <= ST_OK;
        end
      end
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign pr_start_o = (state_q == S_START);
  assign done_o     = done_q;
  assign pass_o     = pass_q;
  assign code_o     = code_q;

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pr_start_o |=> !pr_start_o); // R2
  AST_START_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pr_start_o |-> !pr_valid_o); // R2
  AST_PAD_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pad |-> !src_ready_o); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!pr_valid_o && !src_ready_o && !pr_start_o)); // R11
endmodule

// File: tb/pr_stream_seq_bench.sv
module pr_stream_seq_bench;
  localparam int          DW   = 32;
  localparam logic [31:0] FILL = 32'hF0F0_F0F0;
  localparam int SC_NORM = 0, SC_ERR = 1, SC_LATE = 2, SC_STAT = 3, SC_TMO = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [15:0] wcnt = '0;
  logic [15:0] tmo = '0;
  logic        busy, done, pass;
  logic [2:0]  code;
  logic [31:0] src_data = '0;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic        start;
  logic [31:0] pr_data;
  logic        pr_valid;
  logic        ready = 1'b0;
  logic [2:0]  status = 3'b000;
  logic        freeze = 1'b0;

  always #5 clk = ~clk;

  pr_stream_seq #(.DW(DW), .CNT_W(16), .TO_W(16), .SETTLE(4), .FILL_EN(1'b1), .FILL_WORD(FILL))
  u_pr_stream_seq (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .word_cnt_i(wcnt), .timeout_i(tmo),
    .busy_o(busy), .done_o(done), .pass_o(pass), .code_o(code),
    .src_data_i(src_data), .src_valid_i(src_valid), .src_ready_o(src_ready),
    .pr_start_o(start), .pr_data_o(pr_data), .pr_valid_o(pr_valid),
    .pr_ready_i(ready), .pr_status_i(status), .pr_freeze_i(freeze)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit wd_hit = 0;
  int run_id = 0, scen = 0, errat = 0, tail = 0;
  logic [2:0] errcode = 3'b000;
  int s_idx = 0, s_n = 0, c_need = 0, c_got = 0, c_tail = 0, c_late = 0;
  int c_extra = 0, c_bad = 0, start_cnt = 0;
  bit c_act = 0, c_errd = 0, start_vbad = 0, busy_bad = 0, fill_seen = 0;
  bit done_seen = 0, r_pass = 0;
  logic [2:0] r_code = 3'b000;

  function automatic logic [31:0] wval(int r, int i);
    return {16'(r) ^ 16'h1357, 16'(i)};
  endfunction

  function automatic logic [2:0] exp_code(int sc, logic [2:0] ec);
    case (sc)
      SC_ERR:  return ec;
      SC_LATE: return 3'b010;
      SC_TMO:  return 3'b100;
      default: return 3'b101;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample 1 ns later
  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > 150000) wd_hit = 1;
    if (c_late > 0) begin
      c_late--;
      if (c_late == 0) status = 3'b010;
    end
    src_valid = (s_idx < s_n) && ($urandom_range(3) != 0);
    src_data  = wval(run_id, s_idx);
    if (c_act) begin
      if (scen == SC_ERR && c_got == errat && !c_errd) begin
        status = errcode;
        c_errd = 1;
      end
      if (c_errd || c_got >= c_need) begin
        ready = 1'b0;
        if (c_tail > 0) c_tail--;
        else begin
          case (scen)
            SC_NORM: begin freeze = 1'b0; status = 3'b101; end
            SC_STAT: status = 3'b101;
            SC_LATE: begin freeze = 1'b0; status = 3'b101; c_late = 2; end
            SC_ERR:  freeze = 1'b0;
            default: ;
          endcase
          c_act = 0;
        end
      end else ready = ($urandom_range(3) != 0);
    end else ready = 1'b0;
    #1;
    if (start) begin
      start_cnt++;
      if (pr_valid) start_vbad = 1;
      if (!busy) busy_bad = 1;
      status = 3'b100;
      freeze = 1'b1;
      c_act = 1; c_got = 0; c_errd = 0; c_tail = tail;
    end
    if (pr_valid && ready) begin
      if (c_got < c_need && !c_errd) begin
        if (pr_data !== wval(run_id, c_got)) c_bad++;
        c_got++;
      end else c_extra++;
    end
    if (src_valid && src_ready) s_idx++;
    if (busy && c_got == c_need && !c_errd && pr_valid && pr_data == FILL && !src_ready)
      fill_seen = 1;
    if (done) begin
      done_seen = 1;
      r_pass = pass;
      r_code = code;
    end
  endtask

  task automatic run(int sc, int n, int ea, logic [2:0] ec, int tl, int to_cyc, int extra_at);
    int k;
    int exp_w;
    logic [2:0] ecd;
    run_id++;
    scen = sc; s_idx = 0; s_n = n; c_need = n; errat = ea; errcode = ec; tail = tl;
    c_extra = 0; c_bad = 0; start_cnt = 0; start_vbad = 0; busy_bad = 0;
    fill_seen = 0; done_seen = 0; c_got = 0;
    wcnt = 16'(n); tmo = 16'(to_cyc); go = 1'b1;
    step();
    go = 1'b0;
    k = 0;
    while (!done_seen && k < 3000 && !wd_hit) begin
      if (k == extra_at) begin go = 1'b1; wcnt = 16'd2; end
      step();
      go = 1'b0;
      k++;
    end
    chk(done_seen, "R10 done seen", int'(done_seen), 1);
    exp_w = (sc == SC_ERR) ? ea : n;
    if (sc == SC_ERR) chk(c_got == exp_w && c_extra == 0, "R7 words before abort", c_got, exp_w);
    else              chk(c_got == exp_w && c_extra == 0, "R3 word count", c_got + c_extra, exp_w);
    chk(c_bad == 0, "R3 word data", c_bad, 0);
    chk(start_cnt == 1 && !start_vbad, "R2 start pulse", start_cnt, 1);
    chk(!busy_bad, "R1 busy with start", int'(busy_bad), 0);
    if (sc != SC_ERR) chk(fill_seen, "R4 filler after data", int'(fill_seen), 1);
    if (extra_at >= 0) chk(c_got == n, "R1 second go ignored", c_got, n);
    ecd = exp_code(sc, ec);
    case (sc)
      SC_NORM: begin
        chk(r_pass && r_code == ecd, "R10 pass result", int'(r_code), int'(ecd));
        chk(r_pass && c_extra == 0, "R5 ready drop not a stall", int'(r_pass), 1);
      end
      SC_ERR:  chk(!r_pass && r_code == ecd, "R7 error code", int'(r_code), int'(ecd));
      SC_LATE: chk(!r_pass && r_code == ecd, "R8 late CRC", int'(r_code), int'(ecd));
      SC_STAT: chk(r_pass && r_code == ecd, "R6 status end", int'(r_code), int'(ecd));
      default: chk(!r_pass && r_code == ecd, "R9 timeout", int'(r_code), int'(ecd));
    endcase
    repeat (3) step();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk(!busy && !done && !start && !pr_valid && !src_ready, "R11 reset state",
        int'({busy, done, start, pr_valid, src_ready}), 0);

    run(SC_NORM, 5, 0, 3'b000, 3, 500, -1);
    run(SC_NORM, 0, 0, 3'b000, 2, 500, -1);
    run(SC_NORM, 1, 0, 3'b000, 0, 500, -1);
    run(SC_ERR, 8, 3, 3'b011, 2, 500, -1);
    run(SC_ERR, 4, 0, 3'b001, 1, 500, -1);
    run(SC_LATE, 4, 0, 3'b000, 1, 500, -1);
    run(SC_TMO, 3, 0, 3'b000, 0, 20, -1);
    run(SC_STAT, 6, 0, 3'b000, 4, 500, -1);
    run(SC_NORM, 6, 0, 3'b000, 2, 500, 3);

    for (int i = 0; i < 30 && !wd_hit; i++) begin
      int sc, n, ea;
      logic [2:0] ec;
      sc = int'($urandom_range(3));
      n  = int'($urandom_range(12, 1));
      ea = int'($urandom_range(n - 1));
      ec = 3'($urandom_range(3, 1));
      run(sc, n, ea, ec, int'($urandom_range(6)), 500, -1);
    end

    if (wd_hit) chk(0, "R10 watchdog", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule